// File: doc/BRIEF.md
# Two-Wire Serial Mode Control Register

This block is the mode control register of a two-wire serial interface. It holds an enable bit, a reception-disable bit, a master-select bit, a transmit-select bit and a 4-bit transfer clock select field. The CPU writes it with a one-cycle write strobe and reads it back at any time on a parallel read port.

The register also updates itself on hardware events reported by the serial engine. These are lost arbitration, a slave address match with the read direction bit set, and a receive overrun in clocked synchronous format. From the register contents the block decodes the operating mode, the pin-drive enable, the serial clock output enable and the slave transmit setup-time count. It also holds a reception gate that is updated when the CPU reads received data.

The bit engine, the baud generator and the address comparator sit outside this block. Only their event strobes reach it.

Top module: `i2c_mode_ctl`

## Requirements
- R1: After reset, rd_data is 8'h00, mode is 2'b00, pins_drive, sclk_out_en and hw_evt are 0, setup_cycles is 0 and rx_allow is 1.
- R2: A write (wr_en=1 with no hardware event) loads wr_data in full, and rd_data returns it from the next cycle. The layout is: bit 7 enable, bit 6 reception disable, bit 5 master select, bit 4 transmit select, bits 3..0 clock select.
- R3: mode equals {master, transmit}: 2'b00 is slave receive, 2'b01 is slave transmit, 2'b10 is master receive and 2'b11 is master transmit.
- R4: pins_drive equals the enable bit. When it is 0, the pins are left to general port use.
- R5: When enable=1, fmt_sync=0, master=1 and arb_lost=1, both master and transmit are cleared on the next edge. With enable=0 or fmt_sync=1, arb_lost has no effect.
- R6: When enable=1, fmt_sync=0, the mode is slave receive and addr_match_rd=1, transmit is set on the next edge. In any other mode or setting, addr_match_rd has no effect.
- R7: When enable=1, fmt_sync=1, master=1 and overrun=1, master is cleared and transmit is kept. In any other case, overrun has no effect.
- R8: If a CPU write and an active hardware event fall in the same cycle, the bits the event touches take the hardware value. Every other bit takes the written value.
- R9: When the CPU reads received data (rxdata_read=1) while transmit=0, rx_allow becomes the inverse of the reception disable bit. When transmit=1, the read leaves rx_allow unchanged.
- R10: In slave transmit, setup_cycles is 10 when clock select bit 3 is 0 and 20 when it is 1. In every other mode it is 0.
- R11: sclk_out_en is 1 exactly when enable=1, fmt_sync=1 and master=1.
- R12: hw_evt is a one-cycle pulse, high in the cycle after a hardware event changed the register, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register read-back |
| fmt_sync | input | 1 | 1 = clocked synchronous format, 0 = two-wire bus format |
| arb_lost | input | 1 | Arbitration-lost strobe |
| addr_match_rd | input | 1 | Slave address matched with read bit strobe |
| overrun | input | 1 | Receive overrun strobe |
| rxdata_read | input | 1 | CPU read of received data strobe |
| mode | output | 2 | Decoded operating mode |
| pins_drive | output | 1 | Bus logic drives the pins |
| rx_allow | output | 1 | Next reception permitted |
| setup_cycles | output | 5 | Slave transmit setup-time count |
| sclk_out_en | output | 1 | Serial clock output enable |
| hw_evt | output | 1 | Hardware-initiated mode change pulse |

## Verification
A CPU write and a hardware event can land in the same cycle. The bench provokes this by driving every event strobe together with a write of the complement of the current value. It does so under both formats, from every register value. It then judges each bit of the read-back separately: touched bits must carry the hardware value, all others the written value, and hw_evt and the decoded mode must agree with that result.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;
  typedef enum logic [1:0] {
    MODE_SRX = 2'b00,
    MODE_STX = 2'b01,
    MODE_MRX = 2'b10,
    MODE_MTX = 2'b11
  } mode_e;

  typedef struct packed {
    logic       en;
    logic       rxdis;
    logic       mst;
    logic       trs;
    logic [3:0] cks;
  } ctl_t;
endpackage

// File: rtl/i2c_mode_evt.sv
module i2c_mode_evt
  import i2c_mode_pkg::*;
(
  input  ctl_t       cur,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       fmt_sync,
  input  logic       arb_lost,
  input  logic       addr_match_rd,
  input  logic       overrun,
  output ctl_t       nxt,
  output logic       load,
  output logic       hw_fire
);
  logic al_hit, am_hit, ov_hit;

  always_comb begin
    al_hit = cur.en & ~fmt_sync & arb_lost & cur.mst;
    am_hit = cur.en & ~fmt_sync & addr_match_rd & ~cur.mst & ~cur.trs;
    ov_hit = cur.en & fmt_sync & overrun & cur.mst;
    hw_fire = al_hit | am_hit | ov_hit;
    load = wr_en | hw_fire;

    nxt = wr_en ? ctl_t'(wr_data) : cur;
    if (al_hit) begin
      nxt.mst = 1'b0;
      nxt.trs = 1'b0;
    end
    if (am_hit) nxt.trs = 1'b1;
    if (ov_hit) nxt.mst = 1'b0;
  end
endmodule

// File: rtl/i2c_mode_regs.sv
module i2c_mode_regs
  import i2c_mode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t nxt,
  input  logic load,
  input  logic hw_fire,
  input  logic rxdata_read,
  output ctl_t cur,
  output logic rx_allow,
  output logic hw_evt
);
  logic rx_load;
  logic rx_nxt;

  always_comb begin
    rx_load = rxdata_read & ~cur.trs;
    rx_nxt  = ~cur.rxdis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else if (load) cur <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_allow <= 1'b1;
    else if (rx_load) rx_allow <= rx_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hw_evt <= 1'b0;
    else hw_evt <= hw_fire;
  end
endmodule

// File: rtl/i2c_mode_dec.sv
module i2c_mode_dec
  import i2c_mode_pkg::*;
#(
  parameter int SETUP_SHORT = 10,
  parameter int SETUP_LONG  = 20,
  parameter int SW          = 5
) (
  input  ctl_t          cur,
  input  logic          fmt_sync,
  output logic [1:0]    mode,
  output logic          pins_drive,
  output logic          sclk_out_en,
  output logic [SW-1:0] setup_cycles
);
  mode_e m;

  always_comb begin
    m           = mode_e'({cur.mst, cur.trs});
    mode        = m;
    pins_drive  = cur.en;
    sclk_out_en = cur.en & fmt_sync & cur.mst;
    if (m == MODE_STX)
      setup_cycles = cur.cks[3] ? SW'(SETUP_LONG) : SW'(SETUP_SHORT);
    else
      setup_cycles = '0;
  end
endmodule

// File: rtl/i2c_mode_ctl.sv
module i2c_mode_ctl
  import i2c_mode_pkg::*;
#(
  parameter int SETUP_SHORT = 10,
  parameter int SETUP_LONG  = 20,
  localparam int SW         = $clog2(SETUP_LONG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  input  logic          fmt_sync,
  input  logic          arb_lost,
  input  logic          addr_match_rd,
  input  logic          overrun,
  input  logic          rxdata_read,
  output logic [1:0]    mode,
  output logic          pins_drive,
  output logic          rx_allow,
  output logic [SW-1:0] setup_cycles,
  output logic          sclk_out_en,
  output logic          hw_evt
);
  ctl_t cur, nxt;
  logic load, hw_fire;

  i2c_mode_evt evt_i (
    .cur(cur), .wr_en(wr_en), .wr_data(wr_data), .fmt_sync(fmt_sync),
    .arb_lost(arb_lost), .addr_match_rd(addr_match_rd), .overrun(overrun),
    .nxt(nxt), .load(load), .hw_fire(hw_fire)
  );

  i2c_mode_regs regs_i (
    .clk(clk), .rst_n(rst_n), .nxt(nxt), .load(load), .hw_fire(hw_fire),
    .rxdata_read(rxdata_read), .cur(cur), .rx_allow(rx_allow), .hw_evt(hw_evt)
  );

  i2c_mode_dec #(.SETUP_SHORT(SETUP_SHORT), .SETUP_LONG(SETUP_LONG), .SW(SW)) dec_i (
    .cur(cur), .fmt_sync(fmt_sync), .mode(mode), .pins_drive(pins_drive),
    .sclk_out_en(sclk_out_en), .setup_cycles(setup_cycles)
  );

  assign rd_data = cur;
endmodule

// File: rtl/i2c_mode_ctl_chk.sv
module i2c_mode_ctl_chk #(
  parameter int SETUP_SHORT = 10,
  parameter int SETUP_LONG  = 20,
  localparam int SW         = $clog2(SETUP_LONG + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic [7:0]    rd_data,
  input logic          fmt_sync,
  input logic          arb_lost,
  input logic          addr_match_rd,
  input logic          overrun,
  input logic          rxdata_read,
  input logic [1:0]    mode,
  input logic          pins_drive,
  input logic          rx_allow,
  input logic [SW-1:0] setup_cycles,
  input logic          sclk_out_en,
  input logic          hw_evt
);
  // R3
  mode_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == rd_data[5:4]);

  // R5
  arb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !fmt_sync && rd_data[5] && arb_lost) |=> (mode == 2'b00 && hw_evt));

  // R6
  addr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !fmt_sync && mode == 2'b00 && addr_match_rd) |=> (rd_data[4] && hw_evt));

  // R7
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && fmt_sync && rd_data[5] && overrun) |=> (!rd_data[5] && hw_evt));

  // R10
  setup_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_cycles == ((mode == 2'b01) ? (rd_data[3] ? SW'(SETUP_LONG) : SW'(SETUP_SHORT)) : SW'(0)));

  // R11
  sclk_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_out_en == (pins_drive && fmt_sync && mode[1]));

  // R12
  evt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !arb_lost && !addr_match_rd && !overrun) |=> ($stable(rd_data) && !hw_evt));
endmodule

bind i2c_mode_ctl i2c_mode_ctl_chk #(.SETUP_SHORT(SETUP_SHORT), .SETUP_LONG(SETUP_LONG)) chk_i (.*);

// File: tb/i2c_mode_ctl_tb_top.sv
module i2c_mode_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       fmt_sync = 1'b0;
  logic       arb_lost = 1'b0;
  logic       addr_match_rd = 1'b0;
  logic       overrun = 1'b0;
  logic       rxdata_read = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] mode;
  logic       pins_drive, rx_allow, sclk_out_en, hw_evt;
  logic [4:0] setup_cycles;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_mode_ctl dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, clock through one posedge, sample at next negedge
  task automatic step(input bit w, input logic [7:0] d, input bit fs,
                      input bit al, input bit am, input bit ov, input bit rr);
    wr_en = w; wr_data = d; fmt_sync = fs;
    arb_lost = al; addr_match_rd = am; overrun = ov; rxdata_read = rr;
    @(negedge clk);
    wr_en = 0; arb_lost = 0; addr_match_rd = 0; overrun = 0; rxdata_read = 0;
  endtask

  task automatic check_outputs(input logic [7:0] r, input bit fs);
    int es;
    es = ({r[5], r[4]} == 2'b01) ? (r[3] ? 20 : 10) : 0;
    chk(rd_data == r, "R2", rd_data, r);
    chk(mode == {r[5], r[4]}, "R3", mode, {r[5], r[4]});
    chk(pins_drive == r[7], "R4", pins_drive, r[7]);
    chk(int'(setup_cycles) == es, "R10", setup_cycles, es);
    chk(sclk_out_en == (r[7] & fs & r[5]), "R11", sclk_out_en, r[7] & fs & r[5]);
  endtask

  initial begin
    while (!done && cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == 8'h00, "R1", rd_data, 0);
    chk(mode == 2'b00 && !pins_drive && !sclk_out_en && !hw_evt, "R1",
        {mode, pins_drive, sclk_out_en, hw_evt}, 0);
    chk(setup_cycles == 0 && rx_allow == 1'b1, "R1", {setup_cycles, rx_allow}, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int fs = 0; fs < 2; fs++) begin
      for (int v = 0; v < 256; v++) begin
        for (int ev = 0; ev < 4; ev++) begin
          for (int w = 0; w < 2; w++) begin
            logic [7:0] base, exp_r, wd;
            bit al, am, ov, fire;
            base = 8'(v);
            step(1, base, fs[0], 0, 0, 0, 0);
            check_outputs(base, fs[0]);
            chk(hw_evt == 1'b0, "R12", hw_evt, 0);
            al = (ev == 1); am = (ev == 2); ov = (ev == 3);
            wd = ~base;
            exp_r = w ? wd : base;
            fire = 0;
            // R5 arbitration loss
            if (al && base[7] && !fs[0] && base[5]) begin exp_r[5] = 0; exp_r[4] = 0; fire = 1; end
            // R6 address match with read bit
            if (am && base[7] && !fs[0] && !base[5] && !base[4]) begin exp_r[4] = 1; fire = 1; end
            // R7 overrun in synchronous master
            if (ov && base[7] && fs[0] && base[5]) begin exp_r[5] = 0; fire = 1; end
            step(w[0], wd, fs[0], al, am, ov, 0);
            // R8 collision: hardware bits win, others written
            chk(rd_data == exp_r, w ? "R8" : (ev == 1 ? "R5" : ev == 2 ? "R6" : "R7"),
                rd_data, exp_r);
            check_outputs(exp_r, fs[0]);
            chk(hw_evt == fire, "R12", hw_evt, fire);
            @(negedge clk);
            chk(hw_evt == 1'b0, "R12", hw_evt, 0);
          end
        end
      end
    end

    // R9 reception gating on receive-data reads
    for (int v = 0; v < 256; v++) begin
      logic [7:0] r;
      bit prev, expv;
      r = 8'(v);
      step(1, r, 0, 0, 0, 0, 0);
      prev = rx_allow;
      expv = r[4] ? prev : ~r[6];
      step(0, 8'h00, 0, 0, 0, 0, 1);
      chk(rx_allow == expv, "R9", rx_allow, expv);
      chk(rd_data == r, "R9", rd_data, r);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule